// File: doc/BRIEF.md
# Power-On Strap Sampling Controller

This block runs a group of shared pads that serve two roles one after the other. Right after supply power is declared good, every pad driver is held in high impedance for a fixed window. During that window an external pull resistor on each pad sets its level. When the window closes, the block freezes each pad level into a configuration word. It then drives every pad low for a short hold phase. After the hold phase it hands each pad over to its clock source.

Each pad's level passes through a synchronizer before it is captured. The configuration word is taken once per power-good interval. It only changes when power-good falls and rises again, which the block treats as a power cycle. A pad's clock is let through only after its source has been seen low at a clock edge. This way the first pulse on the pad is never a truncated high.

Top module: `strap_sampler`

## Requirements
- R1: While `pwrGood` is low, `padOe`, `padOut`, `strapWord` and `strapValid` are all zero, whatever `padIn` and `clkSrc` do.
- R2: For the first `WINDOW_CYCLES - 1` rising clock edges after `pwrGood` goes high, every bit of `padOe` stays 0 and `strapValid` stays 0.
- R3: At rising edge number `WINDOW_CYCLES` after `pwrGood` goes high, `strapValid` becomes 1. Also at that edge, `strapWord` bit i takes the level of `padIn` bit i: a pad pulled to ground gives 0 and a pad pulled to supply gives 1. The pad must be stable for at least `SYNC_STAGES` cycles before that edge.
- R4: Once `strapValid` is 1, changes on `padIn` have no effect on `strapWord` until `pwrGood` falls.
- R5: For `HOLD_CYCLES` cycles starting at the capture edge, every bit of `padOe` is 1 and every bit of `padOut` is 0.
- R6: After the hold phase, `padOe` stays all ones. `padOut` bit i equals `clkSrc` bit i only after a rising edge in this phase at which `clkSrc` bit i was 0. Before such an edge, `padOut` bit i is 0.
- R7: Once `strapValid` is 1, it stays 1 until `pwrGood` falls.
- R8: If `pwrGood` falls and rises again, the whole sequence restarts. A new word is captured from the pad levels present in the new window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| pwrGood | input | 1 | Supply-good level; low acts as asynchronous clear of all state |
| padIn | input | NUM_PADS | Levels read back from the shared pads |
| clkSrc | input | NUM_PADS | Clock source for each pad |
| padOe | output | NUM_PADS | Per-pad driver enable (0 = high impedance) |
| padOut | output | NUM_PADS | Per-pad drive data |
| strapWord | output | NUM_PADS | Captured configuration word, bit i from pad i |
| strapValid | output | 1 | High once the word has been captured, until power-good falls |

## Verification
The bench builds the block with `WINDOW_CYCLES` set to 20 and `HOLD_CYCLES` set to 4. With these values, the exact capture edge and every hold cycle can be checked one by one. Several full power cycles also fit in a short run. With five pads, the all-zero and all-one words and mixed patterns are captured across repeated power-good pulses. Two pads keep their sources high into the run phase, which shows the per-pad low-before-drive rule.

// File: rtl/strap_pkg.sv
package strap_pkg;

  typedef enum logic [1:0] {
    ST_SAMPLE = 2'd0,
    ST_HOLD   = 2'd1,
    ST_RUN    = 2'd2
  } strapStateT;

  typedef struct packed {
    logic capture;
    logic holdLow;
    logic runEn;
  } strapStrobeT;

endpackage

// File: rtl/strap_ctrl.sv
module strap_ctrl
  import strap_pkg::*;
#(
  parameter int WINDOW_CYCLES = 100000,
  parameter int HOLD_CYCLES   = 8
) (
  input  logic        clk,
  input  logic        pwrGood,
  output strapStrobeT strb
);

  localparam int WIN_W  = $clog2(WINDOW_CYCLES + 1);
  localparam int HOLD_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [WIN_W-1:0]  WIN_LAST  = WIN_W'(WINDOW_CYCLES - 1);
  localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(HOLD_CYCLES - 1);

  strapStateT        state;
  logic [WIN_W-1:0]  winCnt;
  logic [HOLD_W-1:0] holdCnt;

  always_ff @(posedge clk or negedge pwrGood) begin
    if (!pwrGood) begin
      state   <= ST_SAMPLE;
      winCnt  <= '0;
      holdCnt <= '0;
    end else begin
      case (state)
        ST_SAMPLE: begin
          if (winCnt == WIN_LAST) state <= ST_HOLD;
          else                    winCnt <= winCnt + 1'b1;
        end
        ST_HOLD: begin
          if (holdCnt == HOLD_LAST) state <= ST_RUN;
          else                      holdCnt <= holdCnt + 1'b1;
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  always_comb begin
    strb.capture = (state == ST_SAMPLE) && (winCnt == WIN_LAST);
    strb.holdLow = (state == ST_HOLD);
    strb.runEn   = (state == ST_RUN);
  end

  // R4: the capture strobe fires once and is followed by the hold phase
  p_single_capture_r4: assert property (@(posedge clk) disable iff (!pwrGood)
    strb.capture |=> (!strb.capture && state == ST_HOLD));

  // R7: the run phase, once reached, is kept until power-good drops
  p_run_sticky_r7: assert property (@(posedge clk) disable iff (!pwrGood)
    (state == ST_RUN) |=> (state == ST_RUN));

  // R5: hold phase only ever leads to run
  p_hold_exit_r5: assert property (@(posedge clk) disable iff (!pwrGood)
    (state == ST_HOLD) |=> (state == ST_HOLD || state == ST_RUN));

endmodule

// File: rtl/strap_datapath.sv
module strap_datapath
  import strap_pkg::*;
#(
  parameter int NUM_PADS    = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                pwrGood,
  input  strapStrobeT         strb,
  input  logic [NUM_PADS-1:0] padIn,
  input  logic [NUM_PADS-1:0] clkSrc,
  output logic [NUM_PADS-1:0] padOe,
  output logic [NUM_PADS-1:0] padOut,
  output logic [NUM_PADS-1:0] strapWord,
  output logic                strapValid
);

  logic [NUM_PADS-1:0] syncQ [SYNC_STAGES];
  logic [NUM_PADS-1:0] clkGate;

  always_ff @(posedge clk or negedge pwrGood) begin
    if (!pwrGood) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= '0;
    end else begin
      syncQ[0] <= padIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
    end
  end

  always_ff @(posedge clk or negedge pwrGood) begin
    if (!pwrGood) begin
      strapWord  <= '0;
      strapValid <= 1'b0;
    end else if (strb.capture) begin
      strapWord  <= syncQ[SYNC_STAGES-1];
      strapValid <= 1'b1;
    end
  end

  assign padOe = {NUM_PADS{strb.holdLow | strb.runEn}};

  for (genvar i = 0; i < NUM_PADS; i++) begin : g_pad
    always_ff @(posedge clk or negedge pwrGood) begin
      if (!pwrGood)                      clkGate[i] <= 1'b0;
      else if (strb.runEn && !clkSrc[i]) clkGate[i] <= 1'b1;
    end

    assign padOut[i] = strb.runEn & clkGate[i] & clkSrc[i];

    // R6: a pad's clock path opens only after its source was seen low
    p_arm_low_r6: assert property (@(posedge clk) disable iff (!pwrGood)
      $rose(clkGate[i]) |-> !$past(clkSrc[i]));
  end

  // R2: no pad is driven before the word is captured
  p_window_quiet_r2: assert property (@(posedge clk) disable iff (!pwrGood)
    !strapValid |-> (padOe == '0));

  // R5: the capture edge opens the drivers with low data
  p_hold_low_r5: assert property (@(posedge clk) disable iff (!pwrGood)
    $rose(strapValid) |-> (padOe == '1 && padOut == '0));

  // R4: captured word is frozen once valid
  p_word_frozen_r4: assert property (@(posedge clk) disable iff (!pwrGood)
    strapValid |=> $stable(strapWord));

  // R7: valid flag is sticky
  p_valid_sticky_r7: assert property (@(posedge clk) disable iff (!pwrGood)
    strapValid |=> strapValid);

endmodule

// File: rtl/strap_sampler.sv
module strap_sampler
  import strap_pkg::*;
#(
  parameter int NUM_PADS      = 5,
  parameter int WINDOW_CYCLES = 100000,
  parameter int HOLD_CYCLES   = 8,
  parameter int SYNC_STAGES   = 2
) (
  input  logic                clk,
  input  logic                pwrGood,
  input  logic [NUM_PADS-1:0] padIn,
  input  logic [NUM_PADS-1:0] clkSrc,
  output logic [NUM_PADS-1:0] padOe,
  output logic [NUM_PADS-1:0] padOut,
  output logic [NUM_PADS-1:0] strapWord,
  output logic                strapValid
);

  strapStrobeT strb;

  strap_ctrl #(
    .WINDOW_CYCLES(WINDOW_CYCLES),
    .HOLD_CYCLES  (HOLD_CYCLES)
  ) u_ctrl (
    .clk    (clk),
    .pwrGood(pwrGood),
    .strb   (strb)
  );

  strap_datapath #(
    .NUM_PADS   (NUM_PADS),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk       (clk),
    .pwrGood   (pwrGood),
    .strb      (strb),
    .padIn     (padIn),
    .clkSrc    (clkSrc),
    .padOe     (padOe),
    .padOut    (padOut),
    .strapWord (strapWord),
    .strapValid(strapValid)
  );

endmodule

// File: tb/strap_sampler_tb.sv
`timescale 1ns/1ps
module strap_sampler_tb;

  localparam int N = 5;
  localparam int W = 20;
  localparam int H = 4;

  logic         clk = 1'b0;
  logic         pwrGood = 1'b0;
  logic [N-1:0] padIn = '0;
  logic [N-1:0] clkSrc = '0;
  logic [N-1:0] padOe, padOut, strapWord;
  logic         strapValid;

  int checks = 0;
  int failures = 0;
  logic [N-1:0] expQ[$];
  logic prevValid = 1'b0;

  always #10 clk = ~clk;

  strap_sampler #(
    .NUM_PADS(N), .WINDOW_CYCLES(W), .HOLD_CYCLES(H), .SYNC_STAGES(2)
  ) u_dut (
    .clk(clk), .pwrGood(pwrGood), .padIn(padIn), .clkSrc(clkSrc),
    .padOe(padOe), .padOut(padOut), .strapWord(strapWord), .strapValid(strapValid)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Monitor: pops expected words at each rising edge of the valid flag (R3)
  initial begin
    forever begin
      @(negedge clk);
      if (strapValid && !prevValid) begin
        if (expQ.size() == 0) check(1'b0, "R3 unexpected capture", 32'(strapWord), 0);
        else begin
          logic [N-1:0] e;
          e = expQ.pop_front();
          check(strapWord == e, "R3 scoreboard", 32'(strapWord), 32'(e));
        end
      end
      prevValid = strapValid;
    end
  end

  task automatic checkOff(input string req);
    check(padOe == '0 && padOut == '0 && strapWord == '0 && strapValid == 1'b0,
          req, {padOe, padOut, strapWord, strapValid}, 0);
  endtask

  // Driver: one full power-good interval with a given strap pattern
  task automatic runSequence(input logic [N-1:0] word);
    bit bad;
    padIn = word;
    clkSrc = '1;
    expQ.push_back(word);
    pwrGood = 1'b1;
    bad = 0;
    for (int i = 1; i < W; i++) begin
      cyc();
      if (padOe != '0 || strapValid) bad = 1;
    end
    check(!bad, "R2 window quiet", 32'(padOe), 0);
    cyc();
    check(strapValid == 1'b1, "R3 valid at capture edge", 32'(strapValid), 1);
    check(strapWord == word, "R3 word value", 32'(strapWord), 32'(word));
    check(padOe == '1 && padOut == '0, "R5 hold first cycle", {padOe, padOut}, {N'('1), N'(0)});
    padIn = ~word;
    clkSrc = 5'b00011;
    bad = 0;
    for (int i = 1; i < H; i++) begin
      cyc();
      if (padOe != '1 || padOut != '0) bad = 1;
    end
    check(!bad, "R5 hold remaining cycles", {padOe, padOut}, {N'('1), N'(0)});
    cyc(); // first run-phase cycle, gates still closed
    check(padOut == '0 && padOe == '1, "R6 run entry low", {padOe, padOut}, {N'('1), N'(0)});
    cyc(); // pads 2..4 armed, pads 0..1 not
    clkSrc = '1;
    #1;
    check(padOut == 5'b11100, "R6 only low-seen pads drive", 32'(padOut), 32'(5'b11100));
    clkSrc = '0;
    cyc();
    clkSrc = '1;
    #1;
    check(padOut == '1, "R6 all pads drive", 32'(padOut), 32'(N'('1)));
    clkSrc = '0;
    #1;
    check(padOut == '0, "R6 follows source low", 32'(padOut), 0);
    for (int i = 0; i < 5; i++) cyc();
    check(strapWord == word, "R4 pad change ignored", 32'(strapWord), 32'(word));
    check(strapValid == 1'b1, "R7 valid sticky", 32'(strapValid), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    padIn = 5'b10101;
    clkSrc = '1;
    repeat (3) @(negedge clk);
    checkOff("R1 reset state");

    runSequence(5'b10110);
    pwrGood = 1'b0;
    #1;
    checkOff("R1 after power-good drop");
    repeat (2) @(negedge clk);

    runSequence(5'b01001); // R8 restart with a new word
    check(strapWord == 5'b01001, "R8 new capture", 32'(strapWord), 32'(5'b01001));
    pwrGood = 1'b0;
    repeat (2) @(negedge clk);
    runSequence(5'b00000);
    pwrGood = 1'b0;
    repeat (2) @(negedge clk);
    runSequence(5'b11111);
    pwrGood = 1'b0;
    repeat (2) @(negedge clk);
    checkOff("R1 final off");
    check(expQ.size() == 0, "R3 all captures seen", 32'(expQ.size()), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 20);
    check(1'b0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule